// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block is a single-port synchronous memory of 32-bit words, split into four 8-bit byte lanes, with a flow-through read path. A read presents the word at the latched address on `dout` in the same cycle as the clock edge that latched the address. There is no output register stage. Addresses are loaded through either of two active-low strobes: one driven by a processor and one driven by a memory controller. After a load, an advance input steps a 2-bit burst counter through the aligned four-word block.

A three-input chip-enable group is judged only on cycles that load a new address. Burst and hold cycles keep the selection latched at the last load. Writes use a global write input that writes all lanes, or a byte-write qualifier combined with per-lane selects. A separate output-enable flag goes with `dout` in place of tri-state pads. It is gated by an asynchronous active-low output enable. It stays low on write cycles, on deselected cycles, and on the first cycle of a read that begins from the deselected state.

Top module: `fts_burst_sram`

## Requirements
- R1: A load happens at a rising edge when `adsc_n` is 0, or when `adsp_n` is 0 and `cs1_n` is 0. On a load, the address is taken from `addr` and the block becomes selected only if `cs1_n`=0, `cs2`=1 and `cs3_n`=0.
- R2: When `cs1_n` is 1, `adsp_n`=0 has no effect: without `adsc_n` or `adv_n` low, the address and the selection are kept.
- R3: On cycles without a load, the chip-enable inputs have no effect on the latched selection.
- R4: On a non-load edge with `adv_n`=0, address bits [1:0] increment and wrap from 3 to 0, and the upper bits are kept. A load takes priority over advance.
- R5: With the block selected and `gw_n`=0, all four lanes are written, whatever `bwe_n` and `bsel_n` are.
- R6: With `gw_n`=1, lane i (bits 8i+7:8i) is written only when `bwe_n`=0 and `bsel_n[i]`=0.
- R7: After an edge, `dout` shows the stored word at the address in effect for that edge, with no extra clock of latency. A word written at that edge is shown as the new value.
- R8: `oe_n`=1 drives `dout_en` low at once, without waiting for a clock edge.
- R9: After a load that selects the block while it was deselected, `dout_en` is 0 for that cycle. It can rise on the next read cycle.
- R10: While deselected, `dout_en` is 0 and write inputs leave memory unchanged.
- R11: A synchronous active-high `rst` leaves the block deselected with `dout_en` 0. Memory contents are not cleared.
- R12: In the cycle after a write edge, `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address; bits [1:0] preload the burst counter |
| adsp_n | input | 1 | Processor address strobe, active low, gated by cs1_n |
| adsc_n | input | 1 | Controller address strobe, active low |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| bsel_n | input | LANES | Per-lane byte selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 32 | Write data |
| dout | output | 32 | Flow-through read data |
| dout_en | output | 1 | High when dout is being driven |

## Verification
The bench targets four areas: the wrap of the burst counter from 3 to 0, the case where `adsp_n` is issued while `cs1_n` is high, chip-enable changes during a burst, and a write that combines a low `bwe_n` with a sparse lane mask. A design that carries into the upper bits would read the wrong four-word block after a wrap. A design that lets the processor strobe through would jump to a new address. A design that re-evaluates the enables mid-burst would drop its selection. A design with inverted lane polarity would corrupt the unselected bytes. The bench also drives `oe_n` high in the middle of a cycle to confirm the gate has no clock edge in its path. It checks that the first cycle out of deselect stays masked while the next hold cycle is driven.

// File: rtl/fts_sram_pkg.sv
package fts_sram_pkg;
  localparam int LANE_W  = 8;
  localparam int BURST_W = 2;
  typedef enum logic [1:0] {CYC_HOLD, CYC_ADV, CYC_LOAD} cyc_kind_e;
endpackage

// File: rtl/fts_burst_addr.sv
module fts_burst_addr
  import fts_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              adv_n,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              eff_sel,
  output logic              fresh,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              sel_q
);
  localparam int HI_W = ADDR_W - BURST_W;

  cyc_kind_e kind;
  logic      picked;

  always_comb begin
    if (!adsc_n || (!adsp_n && !cs1_n)) kind = CYC_LOAD;
    else if (!adv_n)                    kind = CYC_ADV;
    else                                kind = CYC_HOLD;
    picked = !cs1_n && cs2 && !cs3_n;
    case (kind)
      CYC_LOAD: begin
        eff_addr = addr;
        eff_sel  = picked;
      end
      CYC_ADV: begin
        eff_addr = {cur_addr[BURST_W +: HI_W],
                    cur_addr[BURST_W-1:0] + BURST_W'(1)};
        eff_sel  = sel_q;
      end
      default: begin
        eff_addr = cur_addr;
        eff_sel  = sel_q;
      end
    endcase
    fresh = (kind == CYC_LOAD) && picked && !sel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      sel_q    <= 1'b0;
    end else begin
      cur_addr <= eff_addr;
      sel_q    <= eff_sel;
    end
  end
endmodule

// File: rtl/fts_lane_dec.sv
module fts_lane_dec #(
  parameter int LANES = 4
) (
  input  logic             sel,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  output logic [LANES-1:0] lane_we
);
  always_comb begin
    if (!sel)        lane_we = '0;
    else if (!gw_n)  lane_we = '1;
    else if (!bwe_n) lane_we = ~bsel_n;
    else             lane_we = '0;
  end
endmodule

// File: rtl/fts_lane_ram.sv
module fts_lane_ram #(
  parameter int ADDR_W = 6,
  parameter int WIDTH  = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fts_out_gate.sv
module fts_out_gate (
  input  logic clk,
  input  logic rst,
  input  logic eff_sel,
  input  logic wrote,
  input  logic fresh,
  input  logic oe_n,
  output logic dout_en
);
  logic rd_ok_q;

  always_ff @(posedge clk) begin
    if (rst) rd_ok_q <= 1'b0;
    else     rd_ok_q <= eff_sel && !wrote && !fresh;
  end

  assign dout_en = rd_ok_q && !oe_n;
endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram
  import fts_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      adsp_n,
  input  logic                      adsc_n,
  input  logic                      cs1_n,
  input  logic                      cs2,
  input  logic                      cs3_n,
  input  logic                      adv_n,
  input  logic                      gw_n,
  input  logic                      bwe_n,
  input  logic [LANES-1:0]          bsel_n,
  input  logic                      oe_n,
  input  logic [LANES*LANE_W-1:0]   din,
  output logic [LANES*LANE_W-1:0]   dout,
  output logic                      dout_en
);
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic              eff_sel;
  logic              sel_q;
  logic              fresh;
  logic [LANES-1:0]  lane_we;

  fts_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .addr(addr),
    .adsp_n(adsp_n), .adsc_n(adsc_n),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .adv_n(adv_n),
    .eff_addr(eff_addr), .eff_sel(eff_sel), .fresh(fresh),
    .cur_addr(cur_addr), .sel_q(sel_q)
  );

  fts_lane_dec #(.LANES(LANES)) u_dec (
    .sel(eff_sel), .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .lane_we(lane_we)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fts_lane_ram #(.ADDR_W(ADDR_W), .WIDTH(LANE_W)) u_ram (
      .clk(clk), .we(lane_we[g]), .waddr(eff_addr),
      .wdata(din[g*LANE_W +: LANE_W]),
      .raddr(cur_addr),
      .rdata(dout[g*LANE_W +: LANE_W])
    );
  end

  fts_out_gate u_gate (
    .clk(clk), .rst(rst), .eff_sel(eff_sel), .wrote(|lane_we),
    .fresh(fresh), .oe_n(oe_n), .dout_en(dout_en)
  );
endmodule

// File: rtl/fts_burst_sram_chk.sv
module fts_burst_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              adsp_n,
  input logic              adsc_n,
  input logic              cs1_n,
  input logic              cs2,
  input logic              cs3_n,
  input logic              adv_n,
  input logic              oe_n,
  input logic              dout_en,
  input logic              sel_q,
  input logic [ADDR_W-1:0] cur_addr
);
  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    !adsc_n |=> (cur_addr == $past(addr)) &&
                (sel_q == $past(!cs1_n && cs2 && !cs3_n)));

  p_proc_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (adsc_n && !adsp_n && cs1_n) |=> $stable(sel_q));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (adsc_n && (adsp_n || cs1_n) && adv_n) |=> $stable(cur_addr) && $stable(sel_q));

  p_adv_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (adsc_n && (adsp_n || cs1_n) && !adv_n) |=>
      (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1) &&
      (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

  p_oe_gate_r8: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dout_en);

  p_first_mask_r9: assert property (@(posedge clk) disable iff (rst)
    ((!adsc_n || (!adsp_n && !cs1_n)) && !cs1_n && cs2 && !cs3_n && !sel_q)
      |=> !dout_en);

  p_desel_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !sel_q |-> !dout_en);

  p_reset_idle_r11: assert property (@(posedge clk)
    rst |=> !sel_q && !dout_en);
endmodule

bind fts_burst_sram fts_burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
  .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .adv_n(adv_n), .oe_n(oe_n),
  .dout_en(dout_en), .sel_q(sel_q), .cur_addr(cur_addr)
);

// File: tb/tb_fts_burst_sram.sv
module tb_fts_burst_sram;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic adsp_n = 1'b1, adsc_n = 1'b1, cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
  logic adv_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b1;
  logic [NL-1:0] bsel_n = '1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;

  always #5 clk = ~clk;

  fts_burst_sram #(.ADDR_W(AW), .LANES(NL)) dut (
    .clk(clk), .rst(rst), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .adv_n(adv_n), .gw_n(gw_n),
    .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [DW-1:0] rmem [DEPTH];
  logic [AW-1:0] r_addr = '0;
  logic          r_sel = 1'b0;
  logic          r_en_q = 1'b0;

  function automatic logic [NL-1:0] lanes_of(logic g, logic b, logic [NL-1:0] s);
    if (!g) return '1;
    if (!b) return ~s;
    return '0;
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: inputs set now (after a negedge), model updated at the edge,
  // outputs compared at the following negedge
  task automatic cyc(string req, logic sp, logic sc, logic c1, logic c2, logic c3,
                     logic av, logic g, logic b, logic [NL-1:0] s, logic oe,
                     logic [AW-1:0] a, logic [DW-1:0] d);
    logic ld, nsel, fr;
    logic [AW-1:0] na;
    logic [NL-1:0] ln;
    adsp_n = sp; adsc_n = sc; cs1_n = c1; cs2 = c2; cs3_n = c3;
    adv_n = av; gw_n = g; bwe_n = b; bsel_n = s; oe_n = oe; addr = a; din = d;
    @(posedge clk);
    ld = !sc || (!sp && !c1);
    fr = 1'b0;
    if (rst) begin
      nsel = 1'b0; na = '0;
    end else if (ld) begin
      nsel = !c1 && c2 && !c3; na = a; fr = nsel && !r_sel;
    end else begin
      nsel = r_sel;
      na = av ? r_addr : {r_addr[AW-1:2], r_addr[1:0] + 2'd1};
    end
    ln = (nsel && !rst) ? lanes_of(g, b, s) : '0;
    for (int i = 0; i < NL; i++)
      if (ln[i]) rmem[na][i*8 +: 8] = d[i*8 +: 8];
    r_addr = na;
    r_sel  = nsel;
    r_en_q = nsel && (ln == '0) && !fr;
    @(negedge clk);
    check(req, {31'd0, dout_en}, {31'd0, r_en_q && !oe});
    if (r_sel) check(req, dout, rmem[r_addr]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    // R11 reset
    cyc("R11 reset", 1,1,1,0,1, 1,1,1,'1,0, '0, '0);
    cyc("R11 reset", 1,1,1,0,1, 1,1,1,'1,0, '0, '0);
    rst = 1'b0;
    cyc("R11 idle after reset", 1,1,1,1,0, 1,1,1,'1,0, '0, '0);
    // fill with controller strobe and global write; R5 R7 R12
    for (int i = 0; i < DEPTH; i++)
      cyc("R5/R7/R12 fill", 1,0,0,1,0, 1,0,0,4'b1111,0, AW'(i), {$urandom});
    // deselect, then a read load from deselected: R9
    cyc("R10 deselect", 1,0,0,0,0, 1,1,1,'1,0, 6'd3, '0);
    cyc("R10 write while deselected", 1,1,0,1,0, 1,0,1,'1,0, 6'd3, 32'hdead_beef);
    cyc("R9 first read masked", 1,0,0,1,0, 1,1,1,'1,0, 6'd5, '0);
    cyc("R9 second read driven", 1,1,0,1,0, 1,1,1,'1,0, 6'd5, '0);
    // R8 asynchronous output enable
    oe_n = 1'b1; #1;
    check("R8 oe async off", {31'd0, dout_en}, 32'd0);
    oe_n = 1'b0; #1;
    check("R8 oe async on", {31'd0, dout_en}, 32'd1);
    // R4 burst wrap 6,7,4,5 and load priority
    cyc("R1 load 6", 0,1,0,1,0, 1,1,1,'1,0, 6'd6, '0);
    cyc("R4 adv to 7", 1,1,0,1,0, 0,1,1,'1,0, '0, '0);
    cyc("R4 wrap to 4", 1,1,0,1,0, 0,1,1,'1,0, '0, '0);
    cyc("R4 adv to 5", 1,1,0,1,0, 0,1,1,'1,0, '0, '0);
    cyc("R4 load beats adv", 1,0,0,1,0, 0,1,1,'1,0, 6'd12, '0);
    // R2 processor strobe with cs1_n high
    cyc("R2 proc strobe ignored", 0,1,1,1,0, 1,1,1,'1,0, 6'd20, '0);
    // R3 enables during burst
    cyc("R3 enables ignored", 1,1,1,0,1, 1,1,1,'1,0, 6'd30, '0);
    cyc("R3 enables ignored adv", 1,1,1,0,1, 0,1,1,'1,0, 6'd30, '0);
    // R6 byte writes
    cyc("R6 lanes 0 and 2", 1,0,0,1,0, 1,1,0,4'b1010,0, 6'd40, 32'h1122_3344);
    cyc("R6 readback", 1,1,0,1,0, 1,1,1,'1,0, '0, '0);
    cyc("R6 no bwe no write", 1,1,0,1,0, 1,1,1,4'b0000,0, '0, 32'hffff_ffff);
    cyc("R6 readback again", 1,1,0,1,0, 1,1,1,'1,0, '0, '0);
    cyc("R5 global beats bwe", 1,1,0,1,0, 1,0,1,4'b1111,0, '0, 32'hcafe_f00d);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      cyc("R1/R4/R6/R7/R9 random",
          ($urandom_range(0,4) != 0), ($urandom_range(0,4) != 0),
          ($urandom_range(0,4) == 0), ($urandom_range(0,6) != 0),
          ($urandom_range(0,6) == 0), $urandom_range(0,1),
          ($urandom_range(0,6) != 0), ($urandom_range(0,2) != 0),
          NL'($urandom), ($urandom_range(0,6) == 0),
          AW'($urandom), {$urandom});
    end
    finish_run();
  end
endmodule